// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers sixteen hardware request lines into one interrupt signal toward a processor. It is built from two identical eight-line units. The first unit, the primary, talks to the processor. The second unit, the secondary, feeds its own interrupt output into primary input 2. Each unit keeps three 8-bit state words: a mask, a pending word and an in-service word. Each unit also picks a winner among its unmasked pending lines under fixed priority. The lowest line number wins. A winner is forwarded only when it outranks everything that unit is already servicing.

The processor answers the interrupt with two acknowledge pulses. The first pulse moves the winner from pending to in-service. When the primary's winner is input 2, the secondary's winner also moves from pending to in-service. The second pulse presents an 8-bit vector for one cycle. Primary lines 0, 1 and 3..7 give vectors 0x08 + n. Secondary lines 8..15 give vectors 0x70 + (n - 8).

Software uses a small write port for two things. It loads either mask. It sends a non-specific end-of-interrupt to either unit, which clears the highest-priority in-service bit of that unit. A request that came from the secondary needs an end-of-interrupt to both units.

Top module: `cascade_intc`

## Requirements
- R1: After reset, int_o and vec_valid_o are 0, and both masks are all ones, so every line is masked.
- R2: A rising edge on an unmasked line makes it pending, and int_o goes high once that edge has been sampled. A line held high after it has been serviced does not make the same request again.
- R3: A rising edge on a line whose mask bit is 1 is discarded. It never raises int_o, and clearing the mask afterwards does not bring it back.
- R4: Priority is fixed, and a lower line number wins. Primary line n returns vector 0x08 + n.
- R5: The first ack_i pulse latches the winner. The second ack_i pulse makes vec_valid_o high, with the vector on vec_o, for exactly the one cycle after the clock edge that sampled it.
- R6: A pending request is forwarded only if its line outranks every in-service bit of its unit. A higher-priority line can preempt a lower one that is being serviced.
- R7: A non-specific end-of-interrupt clears only the highest-priority in-service bit of the unit it addresses. Any blocked request then becomes eligible again.
- R8: Secondary line n (8..15) returns vector 0x70 + (n - 8) and reaches the processor through primary input 2. An end-of-interrupt sent only to the secondary leaves primary input 2 in service, which keeps primary lines 3..7 blocked.
- R9: irq_i[2] has no effect, because primary input 2 is taken by the secondary.
- R10: An acknowledge that arrives when int_o is low returns vector 0x0F and sets no in-service bit.
- R11: Write-port encoding, with cfg_sel_i: 0 writes the primary mask, 1 writes the secondary mask, 2 sends an end-of-interrupt to the primary, and 3 sends an end-of-interrupt to the secondary. For the mask writes, a 1 in bit n masks line n of that unit, which is line 8 + n on the secondary. Setting primary mask bit 2 hides the whole secondary. The secondary's request reappears when that bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Edge-triggered request lines; bits 15..8 go to the secondary |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_sel_i | input | 2 | Write target (see R11) |
| cfg_data_i | input | 8 | Mask data; ignored for end-of-interrupt |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector present on vec_o this cycle |
| vec_o | output | 8 | Vector number |

## Verification
The bench targets three blocking cases:
- Nested service: if in-service blocking were missing, the lower-priority line 5 would fire while line 3 is still being serviced.
- A lost secondary end-of-interrupt: a design that cleared the primary's bit on its own would let line 4 through too early.
- A primary mask change: if the cascade input were edge-captured, the secondary's request would be lost when the primary mask bit is cleared.

It also checks that masked edges are discarded rather than deferred, and that a line held high does not fire again. It checks the spurious acknowledge path, where a wrong design would mark line 7 in service and then block that line's next request.

// File: rtl/intc_pkg.sv
package intc_pkg;
  parameter int UNIT_W = 8;
  parameter int VEC_W = 8;
  localparam int IDX_W = $clog2(UNIT_W);

  typedef logic [UNIT_W-1:0] vec_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [1:0] {
    SEL_PMASK = 2'd0,
    SEL_SMASK = 2'd1,
    SEL_PEOI  = 2'd2,
    SEL_SEOI  = 2'd3
  } cfg_sel_e;

  // Index of the lowest set bit (highest priority); 0 when empty.
  function automatic idx_t first_set(vec_t v);
    idx_t r = '0;
    for (int i = UNIT_W - 1; i >= 0; i--) begin
      if (v[i]) r = idx_t'(i);
    end
    return r;
  endfunction

  function automatic vec_t bit_of(idx_t i);
    return vec_t'(1) << i;
  endfunction

  // Candidate set beats the in-service set under fixed priority.
  function automatic logic outranks(vec_t cand, vec_t isr);
    if (cand == '0) return 1'b0;
    if (isr == '0) return 1'b1;
    return first_set(cand) < first_set(isr);
  endfunction

  function automatic logic [VEC_W-1:0] vector_for(logic [VEC_W-1:0] base, idx_t i);
    return base + VEC_W'(i);
  endfunction
endpackage

// File: rtl/intc_edge.sv
module intc_edge
  import intc_pkg::*;
#(
  parameter vec_t EDGE_EN = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  vec_t d_i,
  output vec_t rise_o
);
  vec_t prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= d_i;
  end

  for (genvar g = 0; g < UNIT_W; g++) begin : g_bit
    if (EDGE_EN[g]) begin : g_on
      assign rise_o[g] = d_i[g] & ~prev_q[g];
    end else begin : g_off
      assign rise_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import intc_pkg::*;
(
  input  vec_t cand_i,
  input  vec_t isr_i,
  output logic fire_o,
  output idx_t win_o
);
  assign win_o  = first_set(cand_i);
  assign fire_o = outranks(cand_i, isr_i);
endmodule

// File: rtl/intc_unit.sv
module intc_unit
  import intc_pkg::*;
#(
  parameter vec_t LVL_BITS = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  vec_t req_i,
  input  vec_t lvl_i,
  input  logic mask_we_i,
  input  vec_t mask_d_i,
  input  logic eoi_i,
  input  logic take_i,
  output logic fire_o,
  output idx_t win_o,
  output vec_t isr_o,
  output vec_t mask_o
);
  vec_t irr_q, isr_q, mask_q;
  vec_t rise, cand, take_bit, eoi_bit;
  logic fire;
  idx_t win;

  intc_edge #(.EDGE_EN(~LVL_BITS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (req_i),
    .rise_o (rise)
  );

  assign cand = (irr_q | (lvl_i & LVL_BITS)) & ~mask_q;

  intc_resolver u_res (
    .cand_i (cand),
    .isr_i  (isr_q),
    .fire_o (fire),
    .win_o  (win)
  );

  assign take_bit = (take_i && fire) ? bit_of(win) : '0;
  assign eoi_bit  = eoi_i ? (bit_of(first_set(isr_q)) & isr_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
    end else begin
      irr_q <= (irr_q & ~take_bit) | (rise & ~mask_q);
      isr_q <= (isr_q & ~eoi_bit) | take_bit;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign fire_o = fire;
  assign win_o  = win;
  assign isr_o  = isr_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] vec_d_i,
  output logic             take_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  typedef enum logic {ACK_IDLE, ACK_HELD} ack_ph_e;
  ack_ph_e ph_q;
  logic [VEC_W-1:0] held_q;
  logic             vv_q;

  assign take_o = ack_i && (ph_q == ACK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= ACK_IDLE;
      held_q <= '0;
      vv_q   <= 1'b0;
    end else begin
      vv_q <= 1'b0;
      if (ack_i) begin
        if (ph_q == ACK_IDLE) begin
          held_q <= vec_d_i;
          ph_q   <= ACK_HELD;
        end else begin
          vv_q <= 1'b1;
          ph_q <= ACK_IDLE;
        end
      end
    end
  end

  assign vec_valid_o = vv_q;
  assign vec_o       = vv_q ? held_q : '0;
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
#(
  parameter logic [VEC_W-1:0] P_BASE  = 8'h08,
  parameter logic [VEC_W-1:0] S_BASE  = 8'h70,
  parameter int               CASC_IN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*UNIT_W-1:0]   irq_i,
  input  logic                  cfg_we_i,
  input  logic [1:0]            cfg_sel_i,
  input  logic [UNIT_W-1:0]     cfg_data_i,
  input  logic                  ack_i,
  output logic                  int_o,
  output logic                  vec_valid_o,
  output logic [VEC_W-1:0]      vec_o
);
  localparam vec_t CASC_BIT = vec_t'(1) << CASC_IN;
  localparam logic [VEC_W-1:0] SPURIOUS = P_BASE + VEC_W'(UNIT_W - 1);

  logic m_fire, s_fire, ack_take;
  idx_t m_win, s_win;
  vec_t m_isr, s_isr, m_mask, s_mask;
  logic m_eoi, s_eoi, m_mwe, s_mwe;
  logic [VEC_W-1:0] vec_d;

  assign m_mwe = cfg_we_i && (cfg_sel_i == SEL_PMASK);
  assign s_mwe = cfg_we_i && (cfg_sel_i == SEL_SMASK);
  assign m_eoi = cfg_we_i && (cfg_sel_i == SEL_PEOI);
  assign s_eoi = cfg_we_i && (cfg_sel_i == SEL_SEOI);

  intc_unit #(.LVL_BITS(CASC_BIT)) u_prim (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (irq_i[UNIT_W-1:0] & ~CASC_BIT),
    .lvl_i     (s_fire ? CASC_BIT : '0),
    .mask_we_i (m_mwe),
    .mask_d_i  (cfg_data_i),
    .eoi_i     (m_eoi),
    .take_i    (ack_take),
    .fire_o    (m_fire),
    .win_o     (m_win),
    .isr_o     (m_isr),
    .mask_o    (m_mask)
  );

  intc_unit #(.LVL_BITS('0)) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (irq_i[2*UNIT_W-1:UNIT_W]),
    .lvl_i     ('0),
    .mask_we_i (s_mwe),
    .mask_d_i  (cfg_data_i),
    .eoi_i     (s_eoi),
    .take_i    (ack_take && m_fire && (m_win == idx_t'(CASC_IN))),
    .fire_o    (s_fire),
    .win_o     (s_win),
    .isr_o     (s_isr),
    .mask_o    (s_mask)
  );

  always_comb begin
    if (!m_fire)                          vec_d = SPURIOUS;
    else if (m_win == idx_t'(CASC_IN))    vec_d = vector_for(S_BASE, s_win);
    else                                  vec_d = vector_for(P_BASE, m_win);
  end

  intc_ack_seq u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .vec_d_i     (vec_d),
    .take_o      (ack_take),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );

  assign int_o = m_fire;
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter logic [VEC_W-1:0] P_BASE = 8'h08,
  parameter logic [VEC_W-1:0] S_BASE = 8'h70
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             take,
  input logic             m_fire,
  input logic             m_eoi,
  input vec_t             m_mask,
  input vec_t             m_isr
);
  logic [VEC_W-1:0] dp, ds;
  assign dp = vec_o - P_BASE;
  assign ds = vec_o - S_BASE;

  p_vec_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_mask == '1) |-> !int_o);

  p_isr_gains_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m_fire && !m_eoi) |=> ($countones(m_isr) == $past($countones(m_isr)) + 1));

  p_eoi_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eoi && !take && (m_isr != '0)) |=> ($countones(m_isr) == $past($countones(m_isr)) - 1));

  p_spurious_no_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !m_fire && !m_eoi) |=> $stable(m_isr));

  p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ((dp < VEC_W'(UNIT_W)) || (ds < VEC_W'(UNIT_W))));
endmodule

bind cascade_intc intc_chk #(.P_BASE(P_BASE), .S_BASE(S_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_o       (int_o),
  .vec_valid_o (vec_valid_o),
  .vec_o       (vec_o),
  .take        (ack_take),
  .m_fire      (m_fire),
  .m_eoi       (m_eoi),
  .m_mask      (m_mask),
  .m_isr       (m_isr)
);

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_data;
  logic        ack;
  logic        int_o, vec_valid;
  logic [7:0]  vec;
  int checks = 0;
  int fails = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  cascade_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .ack_i(ack),
    .int_o(int_o), .vec_valid_o(vec_valid), .vec_o(vec)
  );

  // {line[3:0], expected vector[7:0]}
  localparam logic [11:0] TBL [8] = '{
    {4'd0, 8'h08}, {4'd1, 8'h09}, {4'd3, 8'h0B}, {4'd5, 8'h0D},
    {4'd7, 8'h0F}, {4'd8, 8'h70}, {4'd10, 8'h72}, {4'd15, 8'h77}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int ln);
    @(negedge clk) irq[ln] = 1'b1;
    @(negedge clk) irq[ln] = 1'b0;
  endtask

  task automatic pulse2(input int a, input int b);
    @(negedge clk) begin irq[a] = 1'b1; irq[b] = 1'b1; end
    @(negedge clk) begin irq[a] = 1'b0; irq[b] = 1'b0; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_sel = sel; cfg_data = d; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    chk("R5", "vec_valid after second ack", int'(vec_valid), 1);
    v = vec;
    @(negedge clk);
    chk("R5", "vec_valid one cycle", int'(vec_valid), 0);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; irq = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "int_o after reset", int'(int_o), 0);
    chk("R1", "vec_valid after reset", int'(vec_valid), 0);
    pulse(0);
    chk("R1", "reset mask hides line 0", int'(int_o), 0);
    wr(2'd0, 8'h00);
    chk("R3", "masked edge dropped after unmask", int'(int_o), 0);
    wr(2'd1, 8'h00);

    // table walk: single line raise, ack, EOI
    for (int i = 0; i < 8; i++) begin
      int ln;
      ln = int'(TBL[i][11:8]);
      pulse(ln);
      chk("R2", $sformatf("int_o line %0d", ln), int'(int_o), 1);
      do_ack(got);
      chk(ln >= 8 ? "R8" : "R4", $sformatf("vector line %0d", ln), int'(got), int'(TBL[i][7:0]));
      if (ln >= 8) wr(2'd3, 8'h00);
      wr(2'd2, 8'h00);
      chk("R7", $sformatf("idle after EOI line %0d", ln), int'(int_o), 0);
    end

    // R4 / R6 / R7 nesting
    pulse2(5, 3);
    chk("R4", "int with two pending", int'(int_o), 1);
    do_ack(got);
    chk("R4", "lower line wins", int'(got), 8'h0B);
    chk("R6", "line 5 blocked by 3 in service", int'(int_o), 0);
    pulse(1);
    chk("R6", "line 1 preempts", int'(int_o), 1);
    do_ack(got);
    chk("R6", "preempt vector", int'(got), 8'h09);
    wr(2'd2, 8'h00);
    chk("R7", "EOI clears only line 1", int'(int_o), 0);
    wr(2'd2, 8'h00);
    chk("R7", "line 5 released", int'(int_o), 1);
    do_ack(got);
    chk("R7", "released vector", int'(got), 8'h0D);
    wr(2'd2, 8'h00);

    // R9
    pulse(2);
    chk("R9", "irq 2 ignored", int'(int_o), 0);

    // R8 EOI to secondary only
    pulse(9);
    do_ack(got);
    chk("R8", "vector line 9", int'(got), 8'h71);
    wr(2'd3, 8'h00);
    chk("R8", "quiet after secondary EOI", int'(int_o), 0);
    pulse(4);
    chk("R8", "line 4 blocked by input 2 in service", int'(int_o), 0);
    wr(2'd2, 8'h00);
    chk("R8", "line 4 after primary EOI", int'(int_o), 1);
    do_ack(got);
    chk("R8", "vector line 4", int'(got), 8'h0C);
    wr(2'd2, 8'h00);

    // R11 primary bit 2 hides secondary
    wr(2'd0, 8'h04);
    pulse(12);
    chk("R11", "secondary hidden by primary bit 2", int'(int_o), 0);
    wr(2'd0, 8'h00);
    chk("R11", "secondary reappears", int'(int_o), 1);
    do_ack(got);
    chk("R11", "vector line 12", int'(got), 8'h74);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h00);

    // R11 / R3 secondary mask
    wr(2'd1, 8'h01);
    pulse(8);
    chk("R11", "secondary mask bit 0 hides line 8", int'(int_o), 0);
    wr(2'd1, 8'h00);
    chk("R3", "line 8 edge discarded", int'(int_o), 0);

    // R10 spurious
    do_ack(got);
    chk("R10", "spurious vector", int'(got), 8'h0F);
    pulse(7);
    chk("R10", "line 7 not blocked after spurious", int'(int_o), 1);
    do_ack(got);
    chk("R10", "line 7 vector", int'(got), 8'h0F);
    wr(2'd2, 8'h00);

    // R2 held level does not retrigger
    @(negedge clk) irq[0] = 1'b1;
    @(negedge clk);
    chk("R2", "held line raises int", int'(int_o), 1);
    do_ack(got);
    chk("R2", "held line vector", int'(got), 8'h08);
    wr(2'd2, 8'h00);
    chk("R2", "no retrigger while held", int'(int_o), 0);
    irq[0] = 1'b0;
    @(negedge clk);
    chk("R2", "quiet after release", int'(int_o), 0);

    report();
  end
endmodule